// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two ways of leaving a trap handler. One of them (DONE) resumes at the instruction after the one that trapped. The other (RETRY) runs the trapping instruction again. The trap stack lives outside this block. It supplies the saved program counter, the saved next program counter and a 64-bit saved state word for the current trap level, along with that level. The block then loads its architectural registers in a single clock.

The saved state word is split into the following fields:

- the two condition-code nibbles,
- the address space identifier,
- a processor-state field, which is masked,
- a window value, stored in reversed numbering, which is brought back into range and turned around,
- optionally, a global-register level.

The trap level output drops by one. One cycle after the restored values appear, a strobe asks the interrupt logic to look again at pending requests. A request made at trap level zero is refused: it gives an illegal-instruction pulse and leaves every register unchanged.

Top module: `trap_return`

## Requirements
- R1: After reset, every restored output and the trap level output are zero, and both strobes are low.
- R2: A DONE request (`ret_retry_i`=0) at a non-zero trap level sets `pc_o` to the saved next-PC and `npc_o` to the saved next-PC plus 4. Both are visible in the cycle after the request.
- R3: A RETRY request (`ret_retry_i`=1) at a non-zero trap level sets `pc_o` to the saved PC and `npc_o` to the saved next-PC.
- R4: On a restore, `xcc_o` takes state bits 39:36 and `icc_o` takes state bits 35:32.
- R5: On a restore, `asi_o` takes state bits 31:24.
- R6: On a restore, `pstate_o` takes state bits 19:8 ANDed with 0xF3F. Bits 7 and 6 of `pstate_o` are therefore always zero.
- R7: On a restore, `cwp_o` becomes NWIN-1-(w mod NWIN), where w is state bits 7:0.
- R8: With the hypervisor option on (the default), `gl_o` takes state bits 42:40 on a restore.
- R9: On a restore, `tl_o` becomes `tl_i` minus one.
- R10: `irq_recheck_o` is high for exactly one cycle, in the cycle after the restored values appear.
- R11: A request with `tl_i`=0 pulses `illegal_o` for one cycle. It changes no output and gives no recheck strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | Trap-return request, one cycle |
| ret_retry_i | input | 1 | 1 = RETRY, 0 = DONE |
| tl_i | input | TL_W | Current trap level |
| saved_pc_i | input | XLEN | Stacked trap PC |
| saved_npc_i | input | XLEN | Stacked trap next-PC |
| saved_state_i | input | 64 | Stacked state word |
| pc_o | output | XLEN | Restored PC |
| npc_o | output | XLEN | Restored next-PC |
| xcc_o | output | 4 | 64-bit condition flags |
| icc_o | output | 4 | 32-bit condition flags |
| asi_o | output | 8 | Address space identifier |
| pstate_o | output | 12 | Processor state |
| cwp_o | output | CWP_W | Internal window pointer |
| gl_o | output | 3 | Global-register level |
| tl_o | output | TL_W | Trap level after return |
| irq_recheck_o | output | 1 | Interrupt recheck strobe |
| illegal_o | output | 1 | Illegal-instruction strobe |

## Verification
Every field register loads on the edge that captures the request, so a wrong slice, mask or window conversion appears on its output one cycle after the request. The bench samples the outputs there. A fault in the two-stage strobe pipeline shows up as a recheck pulse that comes a cycle early, comes late, or lasts two cycles. A broken trap-level-zero guard shows as a changed output next to the illegal pulse. The window tests include values at the top of the range, values beyond it, and values exactly on it, because any error in the modulo or reversal path shows first at these points.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int unsigned ST_W     = 64;
  localparam int unsigned PST_W    = 12;
  localparam logic [PST_W-1:0] PST_MASK = 12'hF3F;
  // state word field positions (decoded by neighbouring trap-entry logic)
  localparam int unsigned XCC_LSB  = 36;
  localparam int unsigned ICC_LSB  = 32;
  localparam int unsigned ASI_LSB  = 24;
  localparam int unsigned PST_LSB  = 8;
  localparam int unsigned WIN_LSB  = 0;
  localparam int unsigned GL_LSB   = 40;
  typedef enum logic { OP_DONE = 1'b0, OP_RETRY = 1'b1 } ret_op_e;
endpackage

// File: rtl/trw_unpack.sv
module trw_unpack
  import trw_pkg::*;
(
  input  logic [ST_W-1:0]  state_i,
  output logic [3:0]       xcc_o,
  output logic [3:0]       icc_o,
  output logic [7:0]       asi_o,
  output logic [PST_W-1:0] pstate_o,
  output logic [7:0]       win_o,
  output logic [2:0]       gl_o
);
  logic unused_bits;
  assign unused_bits = ^{state_i[63:43], state_i[23:20]};

  assign xcc_o    = state_i[XCC_LSB +: 4];
  assign icc_o    = state_i[ICC_LSB +: 4];
  assign asi_o    = state_i[ASI_LSB +: 8];
  assign pstate_o = state_i[PST_LSB +: PST_W] & PST_MASK;
  assign win_o    = state_i[WIN_LSB +: 8];
  assign gl_o     = state_i[GL_LSB  +: 3];
endmodule

// File: rtl/trw_cwp_conv.sv
module trw_cwp_conv #(
  parameter int unsigned NWIN  = 8,
  localparam int unsigned CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [7:0]       win_i,
  output logic [CWP_W-1:0] cwp_o
);
  logic [CWP_W-1:0] red;

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      logic unused_hi;
      assign unused_hi = ^win_i;
      assign red = win_i[CWP_W-1:0];
    end else begin : g_mod
      assign red = CWP_W'(32'(win_i) % NWIN);
    end
  endgenerate

  // stored numbering counts the other way
  assign cwp_o = CWP_W'(NWIN - 1) - red;
endmodule

// File: rtl/trw_pc_sel.sv
module trw_pc_sel
  import trw_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  ret_op_e         op_i,
  input  logic [XLEN-1:0] tpc_i,
  input  logic [XLEN-1:0] tnpc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o
);
  always_comb begin
    if (op_i == OP_RETRY) begin
      pc_o  = tpc_i;
      npc_o = tnpc_i;
    end else begin
      pc_o  = tnpc_i;
      npc_o = tnpc_i + XLEN'(4);
    end
  end
endmodule

// File: rtl/trap_return.sv
module trap_return
  import trw_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NWIN  = 8,
  parameter int unsigned TL_W  = 3,
  parameter bit          HYPER = 1'b1,
  localparam int unsigned CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ret_valid_i,
  input  logic             ret_retry_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [XLEN-1:0]  saved_pc_i,
  input  logic [XLEN-1:0]  saved_npc_i,
  input  logic [63:0]      saved_state_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic [3:0]       xcc_o,
  output logic [3:0]       icc_o,
  output logic [7:0]       asi_o,
  output logic [11:0]      pstate_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [2:0]       gl_o,
  output logic [TL_W-1:0]  tl_o,
  output logic             irq_recheck_o,
  output logic             illegal_o
);
  logic [3:0]       xcc_d, icc_d;
  logic [7:0]       asi_d, win_d;
  logic [PST_W-1:0] pst_d;
  logic [2:0]       gl_d;
  logic [CWP_W-1:0] cwp_d;
  logic [XLEN-1:0]  pc_d, npc_d;
  logic             restore, refuse, restore_q;
  ret_op_e          op;

  assign op      = ret_op_e'(ret_retry_i);
  assign restore = ret_valid_i && (tl_i != '0);
  assign refuse  = ret_valid_i && (tl_i == '0);

  trw_unpack u_unpack (
    .state_i (saved_state_i),
    .xcc_o   (xcc_d),
    .icc_o   (icc_d),
    .asi_o   (asi_d),
    .pstate_o(pst_d),
    .win_o   (win_d),
    .gl_o    (gl_d)
  );

  trw_cwp_conv #(.NWIN(NWIN)) u_cwp (
    .win_i(win_d),
    .cwp_o(cwp_d)
  );

  trw_pc_sel #(.XLEN(XLEN)) u_pcsel (
    .op_i  (op),
    .tpc_i (saved_pc_i),
    .tnpc_i(saved_npc_i),
    .pc_o  (pc_d),
    .npc_o (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= '0;
      npc_o    <= '0;
      xcc_o    <= '0;
      icc_o    <= '0;
      asi_o    <= '0;
      pstate_o <= '0;
      cwp_o    <= '0;
      tl_o     <= '0;
    end else if (restore) begin
      pc_o     <= pc_d;
      npc_o    <= npc_d;
      xcc_o    <= xcc_d;
      icc_o    <= icc_d;
      asi_o    <= asi_d;
      pstate_o <= pst_d;
      cwp_o    <= cwp_d;
      tl_o     <= tl_i - TL_W'(1);
    end
  end

  generate
    if (HYPER) begin : g_gl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      gl_o <= '0;
        else if (restore) gl_o <= gl_d;
      end
    end else begin : g_no_gl
      logic unused_gl;
      assign unused_gl = ^gl_d;
      assign gl_o = '0;
    end
  endgenerate

  // recheck one cycle after the restored values are visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      restore_q     <= 1'b0;
      irq_recheck_o <= 1'b0;
      illegal_o     <= 1'b0;
    end else begin
      restore_q     <= restore;
      irq_recheck_o <= restore_q;
      illegal_o     <= refuse;
    end
  end
endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NWIN  = 8,
  parameter int unsigned TL_W  = 3,
  parameter int unsigned CWP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ret_valid_i,
  input logic             ret_retry_i,
  input logic [TL_W-1:0]  tl_i,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  npc_o,
  input logic [11:0]      pstate_o,
  input logic [CWP_W-1:0] cwp_o,
  input logic [TL_W-1:0]  tl_o,
  input logic             irq_recheck_o,
  input logic             illegal_o
);
  assert_done_npc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !ret_retry_i && tl_i != '0) |=> (npc_o == pc_o + XLEN'(4)));

  assert_pstate_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o[7:6] == 2'b00));

  assert_cwp_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cwp_o) < NWIN));

  assert_tl_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && tl_i != '0) |=> (tl_o == $past(tl_i) - TL_W'(1)));

  assert_recheck_late_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && tl_i != '0) |=> ##1 irq_recheck_o);

  assert_recheck_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_recheck_o && !$past(ret_valid_i && tl_i != '0, 2)) |=> !irq_recheck_o);

  assert_refuse_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && tl_i == '0) |=> (illegal_o && $stable(pc_o) && $stable(npc_o) && $stable(tl_o)));
endmodule

bind trap_return trap_return_chk #(
  .XLEN(XLEN), .NWIN(NWIN), .TL_W(TL_W), .CWP_W(CWP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ret_valid_i(ret_valid_i), .ret_retry_i(ret_retry_i),
  .tl_i(tl_i), .pc_o(pc_o), .npc_o(npc_o), .pstate_o(pstate_o), .cwp_o(cwp_o),
  .tl_o(tl_o), .irq_recheck_o(irq_recheck_o), .illegal_o(illegal_o)
);

// File: tb/sim_trap_return.sv
module sim_trap_return;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned XLEN = 64;
  localparam int unsigned NWIN = 8;
  localparam int unsigned TL_W = 3;
  localparam int unsigned CWP_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic             retry = 1'b0;
  logic [TL_W-1:0]  tl = '0;
  logic [XLEN-1:0]  spc = '0, snpc = '0;
  logic [63:0]      sst = '0;
  logic [XLEN-1:0]  pc, npc;
  logic [3:0]       xcc, icc;
  logic [7:0]       asi;
  logic [11:0]      pst;
  logic [CWP_W-1:0] cwp;
  logic [2:0]       gl;
  logic [TL_W-1:0]  tlo;
  logic             rchk, ill;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_return #(.XLEN(XLEN), .NWIN(NWIN), .TL_W(TL_W), .HYPER(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ret_valid_i(valid), .ret_retry_i(retry), .tl_i(tl),
    .saved_pc_i(spc), .saved_npc_i(snpc), .saved_state_i(sst),
    .pc_o(pc), .npc_o(npc), .xcc_o(xcc), .icc_o(icc), .asi_o(asi), .pstate_o(pst),
    .cwp_o(cwp), .gl_o(gl), .tl_o(tlo), .irq_recheck_o(rchk), .illegal_o(ill)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mk_state(input logic [2:0] g, input logic [3:0] x,
      input logic [3:0] i, input logic [7:0] a, input logic [11:0] p, input logic [7:0] w);
    return {21'd0, g, x, i, a, 4'd0, p, w};
  endfunction

  // one restore, then check fields, recheck timing
  task automatic do_ret(input string tag, input bit rt, input logic [TL_W-1:0] t,
      input logic [63:0] a_pc, input logic [63:0] a_npc, input logic [63:0] st);
    @(negedge clk);
    valid = 1'b1; retry = rt; tl = t; spc = a_pc; snpc = a_npc; sst = st;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " R2/R3 pc"}, pc, rt ? a_pc : a_npc);
    chk({tag, " R2/R3 npc"}, npc, rt ? a_npc : a_npc + 64'd4);
    chk({tag, " R4 xcc"}, 64'(xcc), 64'(st[39:36]));
    chk({tag, " R4 icc"}, 64'(icc), 64'(st[35:32]));
    chk({tag, " R5 asi"}, 64'(asi), 64'(st[31:24]));
    chk({tag, " R6 pstate"}, 64'(pst), 64'(st[19:8] & 12'hF3F));
    chk({tag, " R7 cwp"}, 64'(cwp), 64'(NWIN - 1 - (32'(st[7:0]) % NWIN)));
    chk({tag, " R8 gl"}, 64'(gl), 64'(st[42:40]));
    chk({tag, " R9 tl"}, 64'(tlo), 64'(t - TL_W'(1)));
    chk({tag, " R10 recheck early"}, 64'(rchk), 64'd0);
    @(negedge clk);
    chk({tag, " R10 recheck"}, 64'(rchk), 64'd1);
    @(negedge clk);
    chk({tag, " R10 recheck width"}, 64'(rchk), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 64'd0);
    chk("R1 npc", npc, 64'd0);
    chk("R1 fields", 64'({xcc, icc, asi, pst, cwp, gl, tlo}), 64'd0);
    chk("R1 strobes", 64'({rchk, ill}), 64'd0);
  endtask

  task automatic t_done;
    do_ret("done", 1'b0, 3'd3, 64'h1000, 64'h1004, mk_state(3'd5, 4'hA, 4'h5, 8'h80, 12'h123, 8'd2));
  endtask

  task automatic t_retry;
    do_ret("retry", 1'b1, 3'd1, 64'hFFFF_0000_0000_0040, 64'hFFFF_0000_0000_0044,
           mk_state(3'd2, 4'h3, 4'hC, 8'h14, 12'hFFF, 8'd7));
  endtask

  task automatic t_windows;
    do_ret("win9", 1'b1, 3'd7, 64'h20, 64'h24, mk_state(3'd7, 4'h0, 4'hF, 8'hFF, 12'h0C0, 8'd9));
    do_ret("win255", 1'b0, 3'd2, 64'h30, 64'h34, mk_state(3'd0, 4'h1, 4'h1, 8'h01, 12'h800, 8'd255));
    do_ret("win0", 1'b0, 3'd2, 64'h50, 64'hFFFF_FFFF_FFFF_FFFC, mk_state(3'd1, 4'h6, 4'h9, 8'h00, 12'h03F, 8'd0));
    do_ret("win8", 1'b1, 3'd4, 64'h60, 64'h64, mk_state(3'd3, 4'hF, 4'h0, 8'h7F, 12'hF00, 8'd8));
  endtask

  task automatic t_illegal;
    logic [63:0] pc0, npc0;
    logic [TL_W-1:0] tl0;
    pc0 = pc; npc0 = npc; tl0 = tlo;
    @(negedge clk);
    valid = 1'b1; retry = 1'b0; tl = '0; spc = 64'hDEAD; snpc = 64'hBEEF;
    sst = mk_state(3'd6, 4'h7, 4'h7, 8'h77, 12'h777, 8'd3);
    @(negedge clk);
    valid = 1'b0;
    chk("R11 illegal", 64'(ill), 64'd1);
    chk("R11 pc held", pc, pc0);
    chk("R11 npc held", npc, npc0);
    chk("R11 tl held", 64'(tlo), 64'(tl0));
    @(negedge clk);
    chk("R11 illegal width", 64'(ill), 64'd0);
    chk("R11 no recheck", 64'(rchk), 64'd0);
    @(negedge clk);
    chk("R11 no recheck late", 64'(rchk), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_done();
    t_retry();
    t_windows();
    t_illegal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule